// File: doc/BRIEF.md
# Interrupt Status Unit with Per-Source Clear

This unit sits between the event logic of a two-wire serial bus controller and the register access path. It records twelve event sources in a raw status word. A software-programmed enable mask filters that word into a masked status word and a single interrupt line. Ten of the sources are sticky. A pulse sets the bit and it stays set until software clears it. Software clears a sticky bit by reading the address set aside for that source. Because of this, a handler that reads the masked status can acknowledge exactly the events it saw, and any event that arrives later is left pending. A separate clear-everything address is also provided. The remaining two sources, receive-full and transmit-empty, mirror FIFO levels.

Alongside the status word, the unit collects the reasons for a transmit abort in a reason register. New reason bits accumulate into it. The register is wiped as a side effect of acknowledging the abort source.

Registers are accessed through a simple read/write strobe port. Read data appears one cycle after the read strobe. All addresses below are word addresses.

Top module: `irq_status_unit`

## Requirements
- R1: Status bit positions are fixed as follows. Bit 0 is receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen and 11 general call. A one-cycle pulse on `src_evt_i[k]` for a sticky source sets raw bit k one cycle later, and the bit stays set until it is cleared. The raw word reads at address 0x00.
- R2: Raw bit 2 equals `rx_full_i` and raw bit 4 equals `tx_empty_i`, each delayed by one cycle. Pulses on `src_evt_i[2]` and `src_evt_i[4]` have no effect on these bits, and neither do clear reads.
- R3: The enable mask is read/write at address 0x02, and only bits 11:0 of the write data are kept. The masked status word reads at address 0x01 and always equals raw AND mask.
- R4: A read of address 0x10+k, for k from 0 to 11 excluding 2 and 4, clears only raw bit k.
- R5: A read of address 0x04 clears every sticky raw bit at once.
- R6: An event pulse on a source in the same cycle as a clear read of that source leaves the bit set.
- R7: The abort reason register at address 0x03 ORs in `abort_evt_i` every cycle until it is cleared. Bits 6 and 8 are reserved and always read as 0. The defined bits are 0 (7-bit address not acknowledged), 1 and 2 (first and second 10-bit address bytes not acknowledged), 3 (data not acknowledged), 4 (general call not acknowledged), 5 (read after general call), 7 (start byte acknowledged), 9 (start byte with restart disabled), 10 (10-bit read with restart disabled), 11 (controller disabled) and 12 (arbitration lost).
- R8: A read of address 0x16 (the clear for source 6) or of address 0x04 empties the reason register. Reason bits arriving in that same cycle are kept.
- R9: `irq_o` is registered and always equals the OR of raw AND mask in the same cycle. A mask of zero holds it low.
- R10: `rdata_o` carries the addressed value in the cycle after `rd_en_i`, and is 0 in any cycle not preceded by a read. Clear addresses and unmapped addresses read as 0. Writes to any address other than 0x02 are ignored.
- R11: While `rst` is high, raw, mask, reason, `rdata_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | 12 | Single-cycle event pulses, one per status bit |
| rx_full_i | input | 1 | Receive FIFO at or above threshold (level) |
| tx_empty_i | input | 1 | Transmit FIFO at or below threshold (level) |
| abort_evt_i | input | 13 | Abort reason bits to accumulate |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with its default parameters: a 6-bit address and a 32-bit data path. With a 6-bit address, random reads reach all 64 word addresses. This covers the unmapped holes between the status registers and the clear block, as well as the addresses beyond it. The 32-bit write data lets random mask writes carry junk in bits 31:12, which must never reach the mask. A behavioural model runs alongside the design and compares `irq_o` and `rdata_o` every cycle. It does this through directed races between events and clear reads, and then through long random mixes of events, reasons, level changes, reads and writes.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int N_SRC      = 12;
  localparam int RSN_W      = 13;
  localparam int SRC_RXFULL = 2;
  localparam int SRC_TXEMPT = 4;
  localparam int SRC_ABORT  = 6;

  localparam logic [N_SRC-1:0] LEVEL_SRC =
    N_SRC'((1 << SRC_RXFULL) | (1 << SRC_TXEMPT));
  localparam logic [RSN_W-1:0] RSN_VALID = 13'h1EBF;

  localparam int A_RAW      = 0;
  localparam int A_MASKED   = 1;
  localparam int A_MASK     = 2;
  localparam int A_REASON   = 3;
  localparam int A_CLR_ALL  = 4;
  localparam int A_CLR_BASE = 16;
endpackage

// File: rtl/isu_src_bank.sv
module isu_src_bank
  import isu_pkg::*;
#(
  parameter int           N   = N_SRC,
  parameter logic [N-1:0] LVL = LEVEL_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_nxt_o,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] raw_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    if (LVL[k]) begin : g_level
      assign raw_nxt_o[k] = lvl_i[k];

      // R2
      lvl_hi_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_i[k] |=> raw_q[k]);
      // R2
      lvl_lo_chk: assert property (@(posedge clk) disable iff (rst)
        !lvl_i[k] |=> !raw_q[k]);
    end else begin : g_sticky
      assign raw_nxt_o[k] = (raw_q[k] & ~clr_i[k]) | set_i[k];

      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i[k] |=> raw_q[k]);
      // R4
      clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i[k] && !set_i[k] |=> !raw_q[k]);
      // R1
      sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        raw_q[k] && !clr_i[k] |=> raw_q[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_nxt_o;
  end

  assign raw_o = raw_q;

  logic unused_bank;
  assign unused_bank = ^{set_i & LVL, lvl_i & ~LVL, clr_i & LVL};
endmodule

// File: rtl/isu_reason.sv
module isu_reason
  import isu_pkg::*;
#(
  parameter int           W     = RSN_W,
  parameter logic [W-1:0] VALID = RSN_VALID
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] abt_i,
  input  logic         clr_i,
  output logic [W-1:0] rsn_o
);
  logic [W-1:0] rsn_q;

  always_ff @(posedge clk) begin
    if (rst) rsn_q <= '0;
    else     rsn_q <= (clr_i ? '0 : rsn_q) | (abt_i & VALID);
  end

  assign rsn_o = rsn_q;

  // R8
  rsn_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> rsn_q == ($past(abt_i) & VALID));
  // R7
  rsn_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (rsn_q & $past(rsn_q)) == $past(rsn_q));

  logic unused_rsn;
  assign unused_rsn = ^(abt_i & ~VALID);
endmodule

// File: rtl/isu_regs.sv
module isu_regs
  import isu_pkg::*;
#(
  parameter int           N   = N_SRC,
  parameter int           AW  = 6,
  parameter int           DW  = 32,
  parameter logic [N-1:0] LVL = LEVEL_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N-1:0]     raw_i,
  input  logic [RSN_W-1:0] rsn_i,
  output logic [N-1:0]     mask_o,
  output logic [N-1:0]     mask_nxt_o,
  output logic [N-1:0]     clr_o,
  output logic             clr_rsn_o,
  output logic [DW-1:0]    rdata_o
);
  logic [N-1:0]  mask_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_mux;
  logic          clr_all;
  logic          mask_wr;

  assign mask_wr    = wr_i && (addr_i == AW'(A_MASK));
  assign mask_nxt_o = mask_wr ? wdata_i[N-1:0] : mask_q;
  assign clr_all    = rd_i && (addr_i == AW'(A_CLR_ALL));

  for (genvar k = 0; k < N; k++) begin : g_clr
    if (LVL[k]) begin : g_none
      assign clr_o[k] = 1'b0;
    end else begin : g_dec
      assign clr_o[k] = clr_all || (rd_i && (addr_i == AW'(A_CLR_BASE + k)));
    end
  end

  assign clr_rsn_o = clr_o[SRC_ABORT];

  always_comb begin
    case (addr_i)
      AW'(A_RAW):    rd_mux = DW'(raw_i);
      AW'(A_MASKED): rd_mux = DW'(raw_i & mask_q);
      AW'(A_MASK):   rd_mux = DW'(mask_q);
      AW'(A_REASON): rd_mux = DW'(rsn_i);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_nxt_o;
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && addr_i == AW'(A_MASK)) |=> $stable(mask_q));
  // R10
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_i && addr_i == AW'(A_CLR_ALL) |=> rdata_q == '0);
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> rdata_q == '0);

  logic unused_wd;
  assign unused_wd = ^wdata_i[DW-1:N];
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_evt_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic [RSN_W-1:0]  abort_evt_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] lvl_vec;
  logic [N_SRC-1:0] raw_q, raw_nxt;
  logic [N_SRC-1:0] mask_q, mask_nxt;
  logic [N_SRC-1:0] clr_vec;
  logic             clr_rsn;
  logic [RSN_W-1:0] rsn_q;
  logic             irq_q;

  always_comb begin
    lvl_vec             = '0;
    lvl_vec[SRC_RXFULL] = rx_full_i;
    lvl_vec[SRC_TXEMPT] = tx_empty_i;
  end

  isu_src_bank #(.N(N_SRC), .LVL(LEVEL_SRC)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_i     (src_evt_i),
    .lvl_i     (lvl_vec),
    .clr_i     (clr_vec),
    .raw_nxt_o (raw_nxt),
    .raw_o     (raw_q)
  );

  isu_reason #(.W(RSN_W), .VALID(RSN_VALID)) u_reason (
    .clk   (clk),
    .rst   (rst),
    .abt_i (abort_evt_i),
    .clr_i (clr_rsn),
    .rsn_o (rsn_q)
  );

  isu_regs #(.N(N_SRC), .AW(ADDR_W), .DW(DATA_W), .LVL(LEVEL_SRC)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (rd_en_i),
    .wr_i       (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .raw_i      (raw_q),
    .rsn_i      (rsn_q),
    .mask_o     (mask_q),
    .mask_nxt_o (mask_nxt),
    .clr_o      (clr_vec),
    .clr_rsn_o  (clr_rsn),
    .rdata_o    (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw_nxt & mask_nxt);
  end

  assign irq_o = irq_q;

  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(raw_q & mask_q));
  // R9
  irq_mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
    mask_q == '0 |-> !irq_o);
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam logic [11:0] LATCH  = 12'hFEB;
  localparam logic [12:0] RVALID = 13'h1EBF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] src_evt = '0;
  logic        rx_full = 1'b0;
  logic        tx_empty = 1'b0;
  logic [12:0] abort_evt = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int fails = 0;
  logic lv_rx = 1'b0;
  logic lv_tx = 1'b0;
  logic [11:0] m_raw = '0;
  logic [11:0] m_mask = '0;
  logic [12:0] m_reason = '0;

  always #4 clk = ~clk;

  irq_status_unit dut (
    .clk (clk), .rst (rst), .src_evt_i (src_evt), .rx_full_i (rx_full),
    .tx_empty_i (tx_empty), .abort_evt_i (abort_evt), .rd_en_i (rd_en),
    .wr_en_i (wr_en), .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
    .irq_o (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic [11:0] e, input logic [12:0] a,
                      input logic rd, input logic wr, input logic [5:0] ad,
                      input logic [31:0] wd);
    logic [31:0] exp_rd;
    logic [11:0] clr;
    logic        exp_irq;
    @(negedge clk);
    src_evt = e; abort_evt = a; rd_en = rd; wr_en = wr; addr = ad; wdata = wd;
    rx_full = lv_rx; tx_empty = lv_tx;
    exp_rd = '0;
    if (rd) begin
      case (ad)
        6'd0: exp_rd = {20'd0, m_raw};
        6'd1: exp_rd = {20'd0, m_raw & m_mask};
        6'd2: exp_rd = {20'd0, m_mask};
        6'd3: exp_rd = {19'd0, m_reason};
        default: exp_rd = '0;
      endcase
    end
    clr = '0;
    if (rd && ad == 6'd4) clr = '1;
    if (rd && ad >= 6'd16 && ad < 6'd28) begin
      int idx = int'(ad) - 16;
      clr[idx] = 1'b1;
    end
    clr = clr & LATCH;
    m_raw = (m_raw & ~clr) | (e & LATCH);
    m_raw[2] = lv_rx;
    m_raw[4] = lv_tx;
    if (clr[6]) m_reason = '0;
    m_reason = m_reason | (a & RVALID);
    if (wr && ad == 6'd2) m_mask = wd[11:0];
    exp_irq = |(m_raw & m_mask);
    @(posedge clk);
    #1;
    check(tag, rdata, exp_rd);
    check("R9", {31'd0, irq}, {31'd0, exp_irq});
  endtask

  task automatic rd_reg(input string tag, input logic [5:0] ad);
    step(tag, '0, '0, 1'b1, 1'b0, ad, '0);
  endtask

  task automatic wr_reg(input string tag, input logic [5:0] ad, input logic [31:0] v);
    step(tag, '0, '0, 1'b0, 1'b1, ad, v);
  endtask

  task automatic pulse(input string tag, input logic [11:0] e, input logic [12:0] a);
    step(tag, e, a, 1'b0, 1'b0, '0, '0);
  endtask

  function automatic string tag_for(input logic [5:0] ad);
    case (ad)
      6'd0: return "R1";
      6'd1, 6'd2: return "R3";
      6'd3: return "R7";
      6'd4: return "R5";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R11", rdata, '0);
    check("R11", {31'd0, irq}, '0);
    @(negedge clk);
    rst = 1'b0;
    rd_reg("R11", 6'd0);
    rd_reg("R11", 6'd2);
    rd_reg("R11", 6'd3);

    // R1 sticky set and hold
    pulse("R1", 12'h001, '0);
    rd_reg("R1", 6'd0);
    pulse("R1", '0, '0);
    rd_reg("R1", 6'd0);

    // R2 level sources
    lv_rx = 1'b1;
    pulse("R2", '0, '0);
    rd_reg("R2", 6'd0);
    rd_reg("R2", 6'd18);
    rd_reg("R2", 6'd0);
    lv_rx = 1'b0;
    pulse("R2", 12'h004, '0);
    pulse("R2", 12'h010, '0);
    rd_reg("R2", 6'd0);

    // R3 / R9 mask
    wr_reg("R9", 6'd2, 32'h0000_0001);
    rd_reg("R3", 6'd1);
    rd_reg("R3", 6'd2);
    wr_reg("R9", 6'd2, 32'hFFFF_F000);
    rd_reg("R3", 6'd2);

    // R4 per-source clear
    pulse("R4", 12'h300, '0);
    wr_reg("R9", 6'd2, 32'h0000_0FFF);
    rd_reg("R4", 6'd25);
    rd_reg("R4", 6'd0);

    // R6 event racing its clear
    step("R6", 12'h100, '0, 1'b1, 1'b0, 6'd24, '0);
    rd_reg("R6", 6'd0);

    // R5 combined clear, level bit unaffected
    lv_tx = 1'b1;
    rd_reg("R5", 6'd4);
    rd_reg("R5", 6'd0);
    lv_tx = 1'b0;
    rd_reg("R5", 6'd0);

    // R7 reason accumulation, reserved bits
    pulse("R7", '0, 13'h0001);
    pulse("R7", '0, 13'h1000);
    pulse("R7", '0, 13'h0140);
    rd_reg("R7", 6'd3);

    // R8 reason wipe, same-cycle reason kept
    step("R8", '0, 13'h0008, 1'b1, 1'b0, 6'd22, '0);
    rd_reg("R8", 6'd3);
    pulse("R8", 12'h040, 13'h0002);
    rd_reg("R8", 6'd4);
    rd_reg("R8", 6'd3);

    // R10 ignored writes, zero reads
    pulse("R10", 12'h800, '0);
    wr_reg("R10", 6'd0, 32'h0000_0000);
    wr_reg("R10", 6'd3, 32'h0000_1FFF);
    rd_reg("R10", 6'd0);
    rd_reg("R10", 6'd3);
    rd_reg("R10", 6'd63);
    rd_reg("R10", 6'd16);
    rd_reg("R10", 6'd9);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] e;
      logic [12:0] a;
      logic        rd, wr;
      logic [5:0]  ad;
      int          sel;
      e  = 12'($urandom) & 12'($urandom) & 12'($urandom);
      a  = ($urandom % 6 == 0) ? 13'(1 << ($urandom % 13)) : 13'd0;
      rd = ($urandom % 2) == 0;
      wr = !rd && ($urandom % 8 == 0);
      sel = $urandom % 4;
      if (sel == 0)      ad = 6'($urandom % 5);
      else if (sel == 1) ad = 6'(16 + $urandom % 12);
      else if (sel == 2) ad = 6'($urandom);
      else               ad = 6'd2;
      if ($urandom % 16 == 0) lv_rx = ~lv_rx;
      if ($urandom % 16 == 0) lv_tx = ~lv_tx;
      step(rd ? tag_for(ad) : "R10", e, a, rd, wr, ad, $urandom);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule